// File: doc/BRIEF.md
# Prevalidated Tag Hit Detector

This block decides, for a 16 KB four-way set-associative data cache, whether a lookup hits and in which way. The stored tags are not physical page numbers. Each line keeps a valid bit and a one-hot vector that names the translation-buffer entry it was filled under. A lookup therefore never compares addresses. The live match lines of the translation CAM are ANDed with the vector of each way in the indexed set, and the result is reduced with an OR. Each way is 4 KB, which does not exceed a page, so the set index is taken from untranslated address bits.

Two lookup ports work in the same cycle, each against its own set index and match lines. Per-way hits, the overall hit and a one-hot way select are combinational from the lookup inputs and the stored state. A line fill writes one vector and sets its valid bit. When a translation entry is replaced, its bit is cleared from every stored vector, so lines that pointed at it stop hitting without a tag walk.

Top module: `pvt_hit_top`

## Requirements
- R1: After reset every line is invalid, and no lookup hits on either port, whatever the match lines are.
- R2: Way w hits when its line in the indexed set is valid and the AND of its stored vector with the match lines is nonzero. An all-zero match input never hits.
- R3: The overall hit output is high exactly when at least one per-way hit is high.
- R4: The way select is one-hot on the hitting way and zero on a miss. Bit w of every way-wide output stands for way w. Software must keep at most one way hitting per lookup.
- R5: The two lookup ports are independent. Each one uses only its own set index and match lines in the same cycle.
- R6: A fill writes the vector and sets valid for the given set and way. Lookups see the new line from the next cycle. A lookup in the fill cycle sees the old contents.
- R7: A translation replacement of entry k clears bit k in every stored vector from the next cycle on. Lines that held only bit k stop hitting. Other bits are kept.
- R8: When a fill and a replacement of entry k happen in the same cycle, bit k is also cleared from the vector being filled.
- R9: A fill changes no other set or way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears valid bits |
| fill_en | input | 1 | Write one line's vector this cycle |
| fill_set | input | 6 | Set written by the fill |
| fill_way | input | 2 | Way written by the fill |
| fill_vec | input | 32 | One-hot translation-entry vector to store |
| tlb_kill_en | input | 1 | A translation entry is being replaced |
| tlb_kill_idx | input | 5 | Index k of the replaced entry |
| rd0_set | input | 6 | Port 0 set index |
| rd0_match | input | 32 | Port 0 CAM match lines |
| rd0_way_hit | output | 4 | Port 0 per-way hit |
| rd0_hit | output | 1 | Port 0 any-way hit |
| rd0_way_sel | output | 4 | Port 0 one-hot way select |
| rd1_set | input | 6 | Port 1 set index |
| rd1_match | input | 32 | Port 1 CAM match lines |
| rd1_way_hit | output | 4 | Port 1 per-way hit |
| rd1_hit | output | 1 | Port 1 any-way hit |
| rd1_way_sel | output | 4 | Port 1 one-hot way select |

## Verification
The hardest case to reach is a replacement that removes one line while another line in the same set must keep hitting. It is also hard to show that a fill in the same cycle as a replacement is already masked. The stimulus table first places lines with different entry vectors in one set. It then replaces one entry and probes that set on both ports in the next cycle: one port looks for the removed entry and the other looks for a surviving one. A directed step issues a fill and a replacement of the same entry together, then probes the filled line.

// File: rtl/pvt_pkg.sv
package pvt_pkg;
    parameter int unsigned CACHE_BYTES_DEF = 16384;
    parameter int unsigned WAYS_DEF        = 4;
    parameter int unsigned LINE_BYTES_DEF  = 64;
    parameter int unsigned TLB_DEF         = 32;
    parameter int unsigned RD_PORTS        = 2;
endpackage

// File: rtl/pvt_tag_store.sv
module pvt_tag_store #(
    parameter int unsigned SETS = 64,
    parameter int unsigned WAYS = 4,
    parameter int unsigned TLB  = 32,
    parameter int unsigned PORTS = 2,
    localparam int unsigned SET_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned TLB_W = $clog2(TLB)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              fill_en,
    input  logic [SET_W-1:0]                  fill_set,
    input  logic [WAY_W-1:0]                  fill_way,
    input  logic [TLB-1:0]                    fill_vec,
    input  logic                              kill_en,
    input  logic [TLB_W-1:0]                  kill_idx,
    input  logic [PORTS-1:0][SET_W-1:0]       rd_set,
    output logic [PORTS-1:0][WAYS-1:0]        rd_vld,
    output logic [PORTS-1:0][WAYS-1:0][TLB-1:0] rd_vec
);
    logic [TLB-1:0] vec_q [SETS][WAYS];
    logic [WAYS-1:0] vld_q [SETS];
    logic [TLB-1:0] keep_mask;

    assign keep_mask = kill_en ? ~(TLB'(1) << kill_idx) : '1;

    // valid bits: cleared by reset, set by a fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else if (fill_en) begin
            vld_q[fill_set][fill_way] <= 1'b1;
        end
    end

    // vectors: no reset, every entry sees the replacement mask
    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (fill_en && int'(fill_set) == s && int'(fill_way) == w) begin
                    vec_q[s][w] <= fill_vec & keep_mask;
                end else begin
                    vec_q[s][w] <= vec_q[s][w] & keep_mask;
                end
            end
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        assign rd_vld[p] = vld_q[rd_set[p]];
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign rd_vec[p][w] = vec_q[rd_set[p]][w];
        end
    end
endmodule

// File: rtl/pvt_hit_port.sv
module pvt_hit_port #(
    parameter int unsigned WAYS = 4,
    parameter int unsigned TLB  = 32
) (
    input  logic [WAYS-1:0]           vld,
    input  logic [WAYS-1:0][TLB-1:0]  vec,
    input  logic [TLB-1:0]            match,
    output logic [WAYS-1:0]           way_hit,
    output logic                      hit,
    output logic [WAYS-1:0]           way_sel
);
    for (genvar w = 0; w < WAYS; w++) begin : g_and_or
        assign way_hit[w] = vld[w] & (|(vec[w] & match));
    end

    assign hit     = |way_hit;
    // isolate lowest set bit so the select stays one-hot
    assign way_sel = way_hit & (~way_hit + WAYS'(1));
endmodule

// File: rtl/pvt_hit_top.sv
module pvt_hit_top
    import pvt_pkg::*;
#(
    parameter int unsigned CACHE_BYTES = CACHE_BYTES_DEF,
    parameter int unsigned WAYS        = WAYS_DEF,
    parameter int unsigned LINE_BYTES  = LINE_BYTES_DEF,
    parameter int unsigned TLB_ENTRIES = TLB_DEF,
    localparam int unsigned SETS  = CACHE_BYTES / (WAYS * LINE_BYTES),
    localparam int unsigned SET_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned TLB_W = $clog2(TLB_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fill_en,
    input  logic [SET_W-1:0]       fill_set,
    input  logic [WAY_W-1:0]       fill_way,
    input  logic [TLB_ENTRIES-1:0] fill_vec,
    input  logic                   tlb_kill_en,
    input  logic [TLB_W-1:0]       tlb_kill_idx,
    input  logic [SET_W-1:0]       rd0_set,
    input  logic [TLB_ENTRIES-1:0] rd0_match,
    output logic [WAYS-1:0]        rd0_way_hit,
    output logic                   rd0_hit,
    output logic [WAYS-1:0]        rd0_way_sel,
    input  logic [SET_W-1:0]       rd1_set,
    input  logic [TLB_ENTRIES-1:0] rd1_match,
    output logic [WAYS-1:0]        rd1_way_hit,
    output logic                   rd1_hit,
    output logic [WAYS-1:0]        rd1_way_sel
);
    localparam int unsigned PORTS = RD_PORTS;

    logic [PORTS-1:0][SET_W-1:0]              rd_set;
    logic [PORTS-1:0][TLB_ENTRIES-1:0]        rd_match;
    logic [PORTS-1:0][WAYS-1:0]               rd_vld;
    logic [PORTS-1:0][WAYS-1:0][TLB_ENTRIES-1:0] rd_vec;
    logic [PORTS-1:0][WAYS-1:0]               way_hit;
    logic [PORTS-1:0]                         hit;
    logic [PORTS-1:0][WAYS-1:0]               way_sel;

    assign rd_set   = {rd1_set, rd0_set};
    assign rd_match = {rd1_match, rd0_match};

    pvt_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TLB(TLB_ENTRIES), .PORTS(PORTS)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .fill_vec(fill_vec),
        .kill_en(tlb_kill_en), .kill_idx(tlb_kill_idx),
        .rd_set(rd_set), .rd_vld(rd_vld), .rd_vec(rd_vec)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        pvt_hit_port #(.WAYS(WAYS), .TLB(TLB_ENTRIES)) hit_i (
            .vld(rd_vld[p]), .vec(rd_vec[p]), .match(rd_match[p]),
            .way_hit(way_hit[p]), .hit(hit[p]), .way_sel(way_sel[p])
        );
    end

    assign rd0_way_hit = way_hit[0];
    assign rd0_hit     = hit[0];
    assign rd0_way_sel = way_sel[0];
    assign rd1_way_hit = way_hit[1];
    assign rd1_hit     = hit[1];
    assign rd1_way_sel = way_sel[1];
endmodule

// File: rtl/pvt_hit_chk.sv
module pvt_hit_chk #(
    parameter int unsigned WAYS = 4,
    parameter int unsigned TLB_ENTRIES = 32,
    parameter int unsigned SET_W = 6,
    parameter int unsigned WAY_W = 2,
    parameter int unsigned TLB_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   fill_en,
    input logic [SET_W-1:0]       fill_set,
    input logic [WAY_W-1:0]       fill_way,
    input logic [TLB_ENTRIES-1:0] fill_vec,
    input logic                   tlb_kill_en,
    input logic [TLB_W-1:0]       tlb_kill_idx,
    input logic [SET_W-1:0]       rd0_set,
    input logic [TLB_ENTRIES-1:0] rd0_match,
    input logic [WAYS-1:0]        rd0_way_hit,
    input logic                   rd0_hit,
    input logic [WAYS-1:0]        rd0_way_sel,
    input logic [SET_W-1:0]       rd1_set,
    input logic [TLB_ENTRIES-1:0] rd1_match,
    input logic [WAYS-1:0]        rd1_way_hit,
    input logic                   rd1_hit,
    input logic [WAYS-1:0]        rd1_way_sel
);
    a_r4_single_hit_p0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd0_way_hit));
    a_r4_single_hit_p1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd1_way_hit));
    a_r4_sel_count_p0: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd0_way_sel) == (rd0_hit ? 1 : 0));
    a_r4_sel_count_p1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd1_way_sel) == (rd1_hit ? 1 : 0));
    a_r2_zero_match_p0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_match == '0) |-> !rd0_hit);
    a_r2_zero_match_p1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_match == '0) |-> !rd1_hit);
    a_r7_kill_p0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tlb_kill_en) && rd0_match == (TLB_ENTRIES'(1) << $past(tlb_kill_idx)))
        |-> !rd0_hit);
    a_r7_kill_p1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tlb_kill_en) && rd1_match == (TLB_ENTRIES'(1) << $past(tlb_kill_idx)))
        |-> !rd1_hit);
    a_r6_fill_seen_p0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_en) && !$past(tlb_kill_en) && rd0_set == $past(fill_set)
         && (rd0_match & $past(fill_vec)) != '0)
        |-> rd0_way_hit[$past(fill_way)]);
    a_r6_fill_seen_p1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_en) && !$past(tlb_kill_en) && rd1_set == $past(fill_set)
         && (rd1_match & $past(fill_vec)) != '0)
        |-> rd1_way_hit[$past(fill_way)]);
endmodule

bind pvt_hit_top pvt_hit_chk #(
    .WAYS(WAYS), .TLB_ENTRIES(TLB_ENTRIES),
    .SET_W(SET_W), .WAY_W(WAY_W), .TLB_W(TLB_W)
) chk_i (.*);

// File: tb/pvt_hit_top_tb_top.sv
`timescale 1ns/1ps
module pvt_hit_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fill_en, tlb_kill_en;
    logic [5:0]  fill_set, rd0_set, rd1_set;
    logic [1:0]  fill_way;
    logic [31:0] fill_vec, rd0_match, rd1_match;
    logic [4:0]  tlb_kill_idx;
    logic [3:0]  rd0_way_hit, rd0_way_sel, rd1_way_hit, rd1_way_sel;
    logic        rd0_hit, rd1_hit;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pvt_hit_top dut_i (.*);

    typedef struct packed {
        logic [1:0]  op;     // 0 none, 1 fill, 2 replace
        logic [5:0]  set;
        logic [1:0]  way;
        logic [31:0] arg;    // fill vector or replaced index
        logic [5:0]  s0;
        logic [31:0] m0;
        logic [5:0]  s1;
        logic [31:0] m1;
        logic [3:0]  e0;
        logic [3:0]  e1;
    } step_t;

    localparam logic [31:0] ALL = 32'hFFFF_FFFF;
    localparam step_t TBL [8] = '{
        '{2'd1, 6'd5,  2'd2, 32'h1 << 3,  6'd5,  32'h1 << 3,  6'd5,  32'h1 << 4, 4'b0100, 4'b0000},
        '{2'd1, 6'd5,  2'd0, 32'h1 << 7,  6'd5,  32'h1 << 7,  6'd6,  32'h1 << 7, 4'b0001, 4'b0000},
        '{2'd1, 6'd63, 2'd3, 32'h1 << 31, 6'd63, 32'h1 << 31, 6'd0,  ALL,        4'b1000, 4'b0000},
        '{2'd1, 6'd0,  2'd1, 32'h1,       6'd0,  ALL,         6'd5,  32'h1 << 3, 4'b0010, 4'b0100},
        '{2'd2, 6'd0,  2'd0, 32'd3,       6'd5,  32'h1 << 3,  6'd5,  32'h1 << 7, 4'b0000, 4'b0001},
        '{2'd1, 6'd5,  2'd2, 32'h1 << 3,  6'd5,  32'h1 << 3,  6'd63, 32'h1 << 31,4'b0100, 4'b1000},
        '{2'd2, 6'd0,  2'd0, 32'd31,      6'd63, 32'h1 << 31, 6'd0,  32'h1,      4'b0000, 4'b0010},
        '{2'd0, 6'd0,  2'd0, 32'd0,       6'd5,  32'h0,       6'd0,  32'h1 << 1, 4'b0000, 4'b0000}
    };

    task automatic check(input string req, input int p, input logic [3:0] wh,
                         input logic h, input logic [3:0] sel, input logic [3:0] e);
        checks++;
        if (wh !== e || h !== (|e) || sel !== e) begin
            errors++;
            $display("FAIL %s port%0d: got way_hit=%b hit=%b sel=%b, expected way_hit=%b hit=%b sel=%b",
                     req, p, wh, h, sel, e, |e, e);
        end
    endtask

    task automatic check_both(input string req, input logic [3:0] e0, input logic [3:0] e1);
        check(req, 0, rd0_way_hit, rd0_hit, rd0_way_sel, e0);
        check(req, 1, rd1_way_hit, rd1_hit, rd1_way_sel, e1);
    endtask

    task automatic idle_inputs();
        fill_en = 0; fill_set = '0; fill_way = '0; fill_vec = '0;
        tlb_kill_en = 0; tlb_kill_idx = '0;
        rd0_set = '0; rd0_match = '0; rd1_set = '0; rd1_match = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: nothing hits after reset
        rd0_set = 6'd0; rd0_match = ALL; rd1_set = 6'd63; rd1_match = ALL;
        #1 check_both("R1 reset", 4'b0000, 4'b0000);

        // R2 R3 R4 R5 R7 R9: table walk
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd0_match = '0; rd1_match = '0;
            fill_en = (TBL[i].op == 2'd1);
            fill_set = TBL[i].set; fill_way = TBL[i].way; fill_vec = TBL[i].arg;
            tlb_kill_en = (TBL[i].op == 2'd2);
            tlb_kill_idx = TBL[i].arg[4:0];
            @(posedge clk);
            @(negedge clk);
            fill_en = 0; tlb_kill_en = 0;
            rd0_set = TBL[i].s0; rd0_match = TBL[i].m0;
            rd1_set = TBL[i].s1; rd1_match = TBL[i].m1;
            #1 check_both($sformatf("R2 R5 R7 R9 table step %0d", i), TBL[i].e0, TBL[i].e1);
        end

        // R6: fill not visible in its own cycle, visible in the next
        @(negedge clk);
        fill_en = 1; fill_set = 6'd10; fill_way = 2'd1; fill_vec = 32'h1 << 9;
        rd0_set = 6'd10; rd0_match = 32'h1 << 9; rd1_set = 6'd10; rd1_match = ALL;
        #1 check_both("R6 same cycle", 4'b0000, 4'b0000);
        @(posedge clk);
        @(negedge clk) fill_en = 0;
        #1 check_both("R6 next cycle", 4'b0010, 4'b0010);

        // R8: fill together with replacement of its own entry
        @(negedge clk);
        rd0_match = '0; rd1_match = '0;
        fill_en = 1; fill_set = 6'd20; fill_way = 2'd3; fill_vec = 32'h1 << 4;
        tlb_kill_en = 1; tlb_kill_idx = 5'd4;
        @(posedge clk);
        @(negedge clk);
        fill_en = 0; tlb_kill_en = 0;
        rd0_set = 6'd20; rd0_match = 32'h1 << 4; rd1_set = 6'd20; rd1_match = ALL;
        #1 check_both("R8 fill with replace", 4'b0000, 4'b0000);

        // R1: a reset in mid-run drops lines that were hitting
        @(negedge clk) rst_n = 0;
        @(posedge clk);
        @(negedge clk) rst_n = 1;
        rd0_set = 6'd10; rd0_match = ALL; rd1_set = 6'd5; rd1_match = ALL;
        #1 check_both("R1 mid-run reset", 4'b0000, 4'b0000);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule